// File: doc/BRIEF.md
# Transmit Completion Report Queue

This block passes per-frame transmit completion reports from an embedded sequencer to a host processor. Each report is 64 bits wide. The sequencer writes it as four 16-bit words through a narrow write port. The host reads it back as two 32-bit registers. The sequencer first stages the three upper words. It then writes the lowest word with its bit 0 set, and that write commits the whole report into a queue of sixteen entries.

The host reads the low register and then the high register. Reading the high register removes the entry. While the queue is empty, both registers read as zero, so a clear bit 0 in the low register means there is no report. A level event tells the host that reports are waiting. A push that arrives while the queue is full is dropped, and it sets a sticky overflow flag. The staged upper words are kept after a commit, so the sequencer can send a new report by rewriting only the words that changed.

Top module: `txstat_fifo`

## Requirements
- R1: The queue holds DEPTH (default 16) reports of 64 bits each. After DEPTH accepted pushes with no pops, all DEPTH reports can be read back intact.
- R2: A write with `seq_wr_sel` = 1, 2 or 3 stages report word 1, 2 or 3. A write with `seq_wr_sel` = 0 and data bit 0 = 1 commits {word3, word2, word1, written word 0} as a new entry. The new entry is visible to the host from the next clock cycle.
- R3: A write with `seq_wr_sel` = 0 and data bit 0 = 0 adds no entry. The queue contents and the event output are unchanged.
- R4: With `host_rd_sel` = 0, `host_rd_data` is {word1, word0} of the oldest entry. With `host_rd_sel` = 1, it is {word3, word2} of that entry.
- R5: A cycle with `host_rd_en` = 1 and `host_rd_sel` = 1 removes the oldest entry. Reading with `host_rd_sel` = 0 removes nothing.
- R6: While the queue is empty, `host_rd_data` reads zero for both selects. A removal request on an empty queue has no effect.
- R7: A commit while the queue is full, with no removal in the same cycle, is dropped. It sets `ovf_flag`, which stays set until reset.
- R8: `tx_done_evt` is high exactly when the queue holds at least one entry.
- R9: The staged words 1 to 3 keep their values after a commit. A later commit that writes only word 0 reuses them.
- R10: Entries are read out in the order they were committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_wr_en | input | 1 | Sequencer word write strobe |
| seq_wr_sel | input | 2 | Index of the report word being written (0 commits) |
| seq_wr_data | input | WORD_W | Report word data; bit 0 of word 0 is the commit trigger |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_sel | input | 1 | 0 selects the low register, 1 the high register (which removes) |
| host_rd_data | output | 2*WORD_W | Selected half of the oldest report, zero when empty |
| tx_done_evt | output | 1 | High while reports are waiting |
| ovf_flag | output | 1 | Sticky flag: a commit was dropped because the queue was full |

## Verification
The first test commits a single report with distinct values in every word. This shows whether the two host registers pair the right words, in the right halves. The next test commits several different reports and reads them back. This separates first-in-first-out order from stale or repeated reads. A commit that writes only word 0 checks that the staged words are kept. Filling the queue to its depth and pushing once more shows where the drop point is. It also shows that the overflow flag stays set after the queue drains. Reads on an empty queue, and word-0 writes with bit 0 clear, confirm that neither one moves the queue.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

  // Number of sequencer words that make up one report
  localparam int unsigned TXS_WORDS = 4;
  // Width of the sequencer word index
  localparam int unsigned TXS_SEL_W = 2;

  // Circular pointer advance that also handles a depth that is not a power of two
  function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

  // Occupancy update after a cycle with optional push and pop
  function automatic int unsigned next_level(input int unsigned lvl, input logic add, input logic take);
    return lvl + (add ? 1 : 0) - (take ? 1 : 0);
  endfunction

endpackage

// File: rtl/txstat_stage.sv
module txstat_stage #(
  parameter int unsigned WORD_W = 16
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wr_en,
  input  logic [txstat_pkg::TXS_SEL_W-1:0]              wr_sel,
  input  logic [WORD_W-1:0]                             wr_data,
  output logic                                          commit_req,
  output logic                                          clear_wr,
  output logic [txstat_pkg::TXS_WORDS*WORD_W-1:0]       entry
);
  localparam int unsigned NW = txstat_pkg::TXS_WORDS;
  localparam int unsigned SW = txstat_pkg::TXS_SEL_W;

  logic [WORD_W-1:0] stg [1:NW-1];
  logic              ctrl_wr;

  assign ctrl_wr    = wr_en && (wr_sel == '0);
  assign commit_req = ctrl_wr && wr_data[0];
  assign clear_wr   = ctrl_wr && !wr_data[0];

  for (genvar k = 1; k < NW; k++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[k] <= '0;
      end else if (wr_en && (wr_sel == SW'(k))) begin
        stg[k] <= wr_data;
      end
    end
  end

  always_comb begin
    entry[WORD_W-1:0] = wr_data;
    for (int k = 1; k < NW; k++) begin
      entry[k*WORD_W +: WORD_W] = stg[k];
    end
  end

endmodule

// File: rtl/txstat_store.sv
module txstat_store #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ENTRY_W = 64,
  localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_req,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop_req,
  output logic               push_ok,
  output logic               pop_ok,
  output logic [ENTRY_W-1:0] head_data,
  output logic [CW-1:0]      level,
  output logic               full,
  output logic               empty
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wr_ptr;
  logic [AW-1:0]      rd_ptr;

  assign empty     = (level == '0);
  assign full      = (level == CW'(DEPTH));
  assign pop_ok    = pop_req && !empty;
  assign push_ok   = push_req && (!full || pop_ok);
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) begin
        wr_ptr <= AW'(txstat_pkg::wrap_inc(32'(wr_ptr), DEPTH));
      end
      if (pop_ok) begin
        rd_ptr <= AW'(txstat_pkg::wrap_inc(32'(rd_ptr), DEPTH));
      end
      level <= CW'(txstat_pkg::next_level(32'(level), push_ok, pop_ok));
    end
  end

endmodule

// File: rtl/txstat_flags.sv
module txstat_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic push_drop,
  input  logic empty,
  output logic ovf_flag,
  output logic done_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (push_drop) begin
      ovf_flag <= 1'b1;
    end
  end

  assign done_evt = !empty;

endmodule

// File: rtl/txstat_fifo.sv
module txstat_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 seq_wr_en,
  input  logic [txstat_pkg::TXS_SEL_W-1:0]     seq_wr_sel,
  input  logic [WORD_W-1:0]                    seq_wr_data,
  input  logic                                 host_rd_en,
  input  logic                                 host_rd_sel,
  output logic [2*WORD_W-1:0]                  host_rd_data,
  output logic                                 tx_done_evt,
  output logic                                 ovf_flag
);
  localparam int unsigned ENTRY_W = txstat_pkg::TXS_WORDS * WORD_W;
  localparam int unsigned HOST_W  = 2 * WORD_W;
  localparam int unsigned CW      = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker
  logic               commit_req;
  logic               clear_wr;
  logic               push_ok;
  logic               pop_ok;
  logic               push_drop;
  logic               pop_req;
  logic               q_full;
  logic               q_empty;
  logic [CW-1:0]      fill_cnt;
  logic [ENTRY_W-1:0] stage_entry;
  logic [ENTRY_W-1:0] head_entry;

  assign pop_req   = host_rd_en && host_rd_sel;
  assign push_drop = commit_req && !push_ok;

  txstat_stage #(.WORD_W(WORD_W)) i_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (seq_wr_en),
    .wr_sel     (seq_wr_sel),
    .wr_data    (seq_wr_data),
    .commit_req (commit_req),
    .clear_wr   (clear_wr),
    .entry      (stage_entry)
  );

  txstat_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (commit_req),
    .push_data (stage_entry),
    .pop_req   (pop_req),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .head_data (head_entry),
    .level     (fill_cnt),
    .full      (q_full),
    .empty     (q_empty)
  );

  txstat_flags i_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_drop (push_drop),
    .empty     (q_empty),
    .ovf_flag  (ovf_flag),
    .done_evt  (tx_done_evt)
  );

  // Host view: low register first, high register second; zero when nothing is queued
  always_comb begin
    if (q_empty) begin
      host_rd_data = '0;
    end else if (host_rd_sel) begin
      host_rd_data = head_entry[HOST_W +: HOST_W];
    end else begin
      host_rd_data = head_entry[0 +: HOST_W];
    end
  end

endmodule

// File: rtl/txstat_fifo_chk.sv
module txstat_fifo_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                commit_req,
  input logic                clear_wr,
  input logic                push_ok,
  input logic                pop_ok,
  input logic                q_full,
  input logic                q_empty,
  input logic [CW-1:0]       fill_cnt,
  input logic                ovf_flag,
  input logic                tx_done_evt,
  input logic                host_rd_sel,
  input logic [2*WORD_W-1:0] host_rd_data
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH)); // R1

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (fill_cnt == $past(fill_cnt) + CW'(1))); // R2

  AST_CLEAR_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && !pop_ok) |=> $stable(fill_cnt)); // R3

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok) |=> (fill_cnt == $past(fill_cnt) - CW'(1))); // R5

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> (host_rd_data == '0)); // R6

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && q_full && !pop_ok) |=> ($stable(fill_cnt) && ovf_flag)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R7

  AST_EVT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_evt == (fill_cnt != '0)); // R8

  AST_SEL_UNUSED_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && host_rd_sel) |-> !pop_ok); // R6

endmodule

bind txstat_fifo txstat_fifo_chk #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .commit_req   (commit_req),
  .clear_wr     (clear_wr),
  .push_ok      (push_ok),
  .pop_ok       (pop_ok),
  .q_full       (q_full),
  .q_empty      (q_empty),
  .fill_cnt     (fill_cnt),
  .ovf_flag     (ovf_flag),
  .tx_done_evt  (tx_done_evt),
  .host_rd_sel  (host_rd_sel),
  .host_rd_data (host_rd_data)
);

// File: tb/test_txstat_fifo.sv
module test_txstat_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int WORD_W     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seq_wr_en = 1'b0;
  logic [1:0]  seq_wr_sel = '0;
  logic [15:0] seq_wr_data = '0;
  logic        host_rd_en = 1'b0;
  logic        host_rd_sel = 1'b0;
  logic [31:0] host_rd_data;
  logic        tx_done_evt;
  logic        ovf_flag;

  int n_chk = 0;
  int n_err = 0;
  int model_cnt = 0;
  logic [63:0] exp_q [$];
  logic [15:0] st1, st2, st3;

  always #(CLK_PERIOD/2) clk = ~clk;

  txstat_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_txstat_fifo (
    .clk          (clk),
    .rst_n        (rst_n),
    .seq_wr_en    (seq_wr_en),
    .seq_wr_sel   (seq_wr_sel),
    .seq_wr_data  (seq_wr_data),
    .host_rd_en   (host_rd_en),
    .host_rd_sel  (host_rd_sel),
    .host_rd_data (host_rd_data),
    .tx_done_evt  (tx_done_evt),
    .ovf_flag     (ovf_flag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    seq_wr_en   = 1'b1;
    seq_wr_sel  = sel;
    seq_wr_data = d;
    if (sel == 2'd1) st1 = d;
    if (sel == 2'd2) st2 = d;
    if (sel == 2'd3) st3 = d;
    @(negedge clk);
    seq_wr_en = 1'b0;
  endtask

  // Driver: commit word 0 using whatever is staged; record expectation
  task automatic commit(input logic [15:0] w0);
    wr_word(2'd0, w0);
    if (model_cnt < DEPTH) begin
      exp_q.push_back({st3, st2, st1, w0});
      model_cnt++;
    end
  endtask

  task automatic push_report(input logic [15:0] w1, input logic [15:0] w2,
                             input logic [15:0] w3, input logic [15:0] w0);
    wr_word(2'd1, w1);
    wr_word(2'd2, w2);
    wr_word(2'd3, w3);
    commit(w0);
  endtask

  // Monitor: read low then high register, compare with scoreboard head
  task automatic pop_check(input string req);
    logic [31:0] lo, hi;
    logic [63:0] exp;
    exp = (exp_q.size() != 0) ? exp_q.pop_front() : 64'd0;
    @(negedge clk);
    host_rd_en  = 1'b1;
    host_rd_sel = 1'b0;
    #1 lo = host_rd_data;
    @(negedge clk);
    host_rd_sel = 1'b1;
    #1 hi = host_rd_data;
    @(negedge clk);
    host_rd_en  = 1'b0;
    host_rd_sel = 1'b0;
    if (model_cnt > 0) model_cnt--;
    chk(req, {hi, lo}, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    st1 = '0; st2 = '0; st3 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: R6 zero reads, R8 no event, R7 no overflow
    chk("R6 reset low reg", {32'd0, host_rd_data}, 64'd0);
    chk("R8 reset event", {63'd0, tx_done_evt}, 64'd0);
    chk("R7 reset overflow", {63'd0, ovf_flag}, 64'd0);

    // R3: word 0 write with bit 0 clear commits nothing
    wr_word(2'd0, 16'hBEE0);
    #1 chk("R3 clear-bit write no event", {63'd0, tx_done_evt}, 64'd0);
    chk("R3 clear-bit write reads zero", {32'd0, host_rd_data}, 64'd0);

    // R2 and R4: single report, word pairing
    push_report(16'h1111, 16'h2222, 16'h3333, 16'hA5A5);
    #1 chk("R8 event after commit", {63'd0, tx_done_evt}, 64'd1);
    // R5: reading low register alone does not remove
    @(negedge clk);
    host_rd_en = 1'b1; host_rd_sel = 1'b0;
    @(negedge clk);
    host_rd_en = 1'b0;
    #1 chk("R5 low read keeps entry", {63'd0, tx_done_evt}, 64'd1);
    pop_check("R4 word pairing");
    #1 chk("R5 high read removes", {63'd0, tx_done_evt}, 64'd0);

    // R9: staged words retained, only word 0 rewritten
    push_report(16'h4B4B, 16'h5C5C, 16'h6D6D, 16'h0001);
    commit(16'h0BB1);
    pop_check("R9 first commit");
    pop_check("R9 reuse staged words");

    // R10: order of several distinct reports
    push_report(16'hAAA1, 16'hAAA2, 16'hAAA3, 16'hAA01);
    push_report(16'hBBB1, 16'hBBB2, 16'hBBB3, 16'hBB03);
    push_report(16'hCCC1, 16'hCCC2, 16'hCCC3, 16'hCC05);
    pop_check("R10 order first");
    pop_check("R10 order second");
    pop_check("R10 order third");

    // R6: removal request on empty queue has no effect
    @(negedge clk);
    host_rd_en = 1'b1; host_rd_sel = 1'b1;
    #1 chk("R6 empty high reads zero", {32'd0, host_rd_data}, 64'd0);
    @(negedge clk);
    host_rd_en = 1'b0; host_rd_sel = 1'b0;
    push_report(16'h7171, 16'h7272, 16'h7373, 16'h7075);
    pop_check("R6 pointers intact after empty pop");

    // R1 and R7: fill to depth, one more is dropped
    for (int i = 0; i < DEPTH; i++) begin
      push_report(16'h1000 + 16'(i), 16'h2000 + 16'(i), 16'h3000 + 16'(i),
                  {8'(i), 8'h11});
    end
    #1 chk("R7 no overflow at depth", {63'd0, ovf_flag}, 64'd0);
    push_report(16'hDEAD, 16'hDEAD, 16'hDEAD, 16'hDEAD);
    #1 chk("R7 overflow on drop", {63'd0, ovf_flag}, 64'd1);
    for (int i = 0; i < DEPTH; i++) begin
      pop_check("R1 full depth readback");
    end
    #1 chk("R8 event clear after drain", {63'd0, tx_done_evt}, 64'd0);
    chk("R7 overflow sticky", {63'd0, ovf_flag}, 64'd1);
    chk("R1 dropped report absent", {32'd0, host_rd_data}, 64'd0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule